// File: doc/BRIEF.md
# Accumulator Multicycle Processor Core

This block is a compact multicycle processor for control tasks. Its state is a 16-bit accumulator, a 16-bit program counter and a 24-bit instruction register. It fetches code and data through one synchronous byte-wide memory port. It runs a small fixed set of operations:

- load, store, add and subtract on the accumulator
- branches: one unconditional, one taken when the accumulator is negative, one taken when it is zero
- byte output and byte input
- a stop instruction

A program is placed in memory from address zero before reset is released. The core then runs until it stops or meets an opcode it does not know. Characters leave through a one-cycle valid strobe. Characters arrive through a valid/ready handshake, and the core waits at that handshake as long as needed.

Every opcode byte is split into fields. Bits 7..4 select the operation class. Bit 3 is a register select that must be 0 for accumulator operations. Bits 2..0 carry the addressing mode, where 000 means immediate and 001 means direct. Words are big-endian: the high byte sits at the lower address.

Top module: `cpu_acc`

## Requirements
- R1: While reset is held and right after it is released, `halted`, `illegal`, `out_valid`, `mem_we` and `in_ready` are low. The accumulator is 0 and the first fetch reads address 0x0000.
- R2: Opcode 0x00 is a 1-byte instruction. Every other legal opcode is followed by a 2-byte operand specifier, high byte first. The program counter advances by 1 after the opcode byte and by 2 after the specifier. The instruction register changes only while fetch bytes are being captured.
- R3: With mode 000 the specifier is the operand itself. With mode 001 the specifier is an address: the word is read as the byte at that address (high) followed by the byte at address+1 (low).
- R4: 0xC0 and 0xC1 load the accumulator. 0xE1 stores the accumulator high byte to the address and the low byte to address+1. For example, with bytes A2,11,00 at addresses n..n+2, a direct load from n+1 gives 0x1100 and a direct load from n gives 0xA211.
- R5: 0x70/0x71 add and 0x80/0x81 subtract the operand, both with 16-bit two's-complement wraparound.
- R6: 0x04 always jumps to the specifier. 0x08 jumps only if accumulator bit 15 is set. 0x0A jumps only if the accumulator is zero. When a branch is not taken, execution continues at the next instruction.
- R7: 0x50 outputs the low byte of the specifier and 0x51 outputs the memory byte at the specifier. Each output is a `out_valid` pulse exactly one cycle long.
- R8: 0x49 raises `in_ready` and waits. In the cycle where `in_valid` is high, it writes `in_data` to the specifier address. Until then, nothing is written and no output is produced.
- R9: 0x00 sets `halted`. `halted` stays set until reset, and while it is set there are no memory reads or writes, no output and no input ready.
- R10: Every byte outside the 14 legal opcodes sets both `halted` and `illegal`, and nothing is executed. This includes 0xE0, the immediate form of store.
- R11: Read data is taken one cycle after `mem_re`. A read and a write are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | ADDR_W | Byte address |
| mem_re | output | 1 | Read request; data is returned on the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte |
| out_valid | output | 1 | Output character strobe |
| out_data | output | 8 | Output character |
| in_valid | input | 1 | Input character present |
| in_data | input | 8 | Input character |
| in_ready | output | 1 | Core waits for input |
| halted | output | 1 | Stopped (sticky) |
| illegal | output | 1 | Stopped on an unknown opcode (sticky) |

## Verification
The assertions check on every cycle that:
- the halt and illegal flags never drop;
- a halted core stays quiet on every port;
- output strobes last one cycle;
- read and write never overlap;
- an accepted input byte goes straight to memory;
- the instruction register moves only during fetch capture.

Only the bench scenarios can show that the results are right. These cover the big-endian word assembly, arithmetic wraparound across a sweep of operand pairs, branch direction for zero, negative and positive values, and the stall of the input handshake. An exhaustive sweep of all 256 opcode bytes confirms that exactly the 14 legal encodings run and all others stop with `illegal` set.

// File: rtl/cpu_acc_pkg.sv
package cpu_acc_pkg;

  typedef enum logic [3:0] {
    S_OP_REQ, S_OP_CAP, S_HI_REQ, S_HI_CAP, S_LO_REQ, S_LO_CAP,
    S_EXEC, S_DHI_REQ, S_DHI_CAP, S_DLO_REQ, S_DLO_CAP,
    S_WR_HI, S_WR_LO, S_IN_WAIT, S_HALT
  } state_e;

  typedef enum logic [3:0] {
    C_STOP, C_BR, C_BRN, C_BRZ, C_IN, C_OUT,
    C_ADD, C_SUB, C_LD, C_ST, C_BAD
  } opcls_e;

  typedef struct packed {
    opcls_e cls;
    logic   direct;
    logic   legal;
  } dec_t;

endpackage

// File: rtl/cpu_acc_rst_sync.sv
module cpu_acc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cpu_acc_decode.sv
module cpu_acc_decode
  import cpu_acc_pkg::*;
(
  input  logic [7:0] op,
  output dec_t       dec
);
  logic [3:0] grp;
  logic       rsel;
  logic [2:0] mode;

  assign grp  = op[7:4];
  assign rsel = op[3];
  assign mode = op[2:0];

  always_comb begin
    dec.cls    = C_BAD;
    dec.direct = (mode == 3'b001);
    dec.legal  = 1'b0;
    case (grp)
      4'h0: begin
        if (op == 8'h00)      begin dec.cls = C_STOP; dec.legal = 1'b1; end
        else if (op == 8'h04) begin dec.cls = C_BR;   dec.legal = 1'b1; end
        else if (op == 8'h08) begin dec.cls = C_BRN;  dec.legal = 1'b1; end
        else if (op == 8'h0A) begin dec.cls = C_BRZ;  dec.legal = 1'b1; end
      end
      4'h4: if (rsel && mode == 3'b001) begin dec.cls = C_IN; dec.legal = 1'b1; end
      4'h5: if (!rsel && mode[2:1] == 2'b00) begin dec.cls = C_OUT; dec.legal = 1'b1; end
      4'h7: if (!rsel && mode[2:1] == 2'b00) begin dec.cls = C_ADD; dec.legal = 1'b1; end
      4'h8: if (!rsel && mode[2:1] == 2'b00) begin dec.cls = C_SUB; dec.legal = 1'b1; end
      4'hC: if (!rsel && mode[2:1] == 2'b00) begin dec.cls = C_LD;  dec.legal = 1'b1; end
      4'hE: if (!rsel && mode == 3'b001)     begin dec.cls = C_ST;  dec.legal = 1'b1; end
      default: ;
    endcase
    if (!dec.legal) dec.cls = C_BAD;
  end
endmodule

// File: rtl/cpu_acc_alu.sv
module cpu_acc_alu
  import cpu_acc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  opcls_e            cls,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] opnd,
  output logic [WORD_W-1:0] acc_nxt,
  output logic              take
);
  always_comb begin
    case (cls)
      C_ADD:   acc_nxt = acc + opnd;
      C_SUB:   acc_nxt = acc - opnd;
      C_LD:    acc_nxt = opnd;
      default: acc_nxt = acc;
    endcase
    case (cls)
      C_BR:    take = 1'b1;
      C_BRN:   take = acc[WORD_W-1];
      C_BRZ:   take = (acc == '0);
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu_acc.sv
module cpu_acc
  import cpu_acc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              halted,
  output logic              illegal
);
  localparam int WORD_W = 16;
  localparam int IR_W   = 3 * 8;

  logic rst_sync_n;

  state_e              state_q, state_d;
  logic [WORD_W-1:0]   pc_q, pc_d, acc_q, acc_d;
  logic [IR_W-1:0]     ir_q, ir_d;
  logic [7:0]          dat_q, dat_d;
  logic                pc_en, acc_en, ir_en, dat_en;
  logic                halt_q, bad_q, bad_set;

  dec_t                dec_cap, dec_ir;
  logic [WORD_W-1:0]   spec, alu_opnd, alu_res;
  logic                alu_take;
  logic [WORD_W-1:0]   addr_w;

  cpu_acc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  cpu_acc_decode u_dec_cap (.op(mem_rdata),      .dec(dec_cap));
  cpu_acc_decode u_dec_ir  (.op(ir_q[IR_W-1 -: 8]), .dec(dec_ir));

  assign spec     = ir_q[WORD_W-1:0];
  assign alu_opnd = (state_q == S_DLO_CAP) ? {dat_q, mem_rdata} : spec;

  cpu_acc_alu #(.WORD_W(WORD_W)) u_alu (
    .cls(dec_ir.cls), .acc(acc_q), .opnd(alu_opnd),
    .acc_nxt(alu_res), .take(alu_take)
  );

  // next-state and datapath control
  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;   pc_en  = 1'b0;
    acc_d     = acc_q;  acc_en = 1'b0;
    ir_d      = ir_q;   ir_en  = 1'b0;
    dat_d     = dat_q;  dat_en = 1'b0;
    bad_set   = 1'b0;
    addr_w    = pc_q;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = 8'h00;
    out_valid = 1'b0;
    out_data  = 8'h00;
    in_ready  = 1'b0;
    case (state_q)
      S_OP_REQ: begin
        mem_re = 1'b1; addr_w = pc_q; state_d = S_OP_CAP;
      end
      S_OP_CAP: begin
        ir_en = 1'b1; ir_d = {mem_rdata, ir_q[15:0]};
        pc_en = 1'b1; pc_d = pc_q + 16'd1;
        if (!dec_cap.legal) begin
          bad_set = 1'b1; state_d = S_HALT;
        end else if (dec_cap.cls == C_STOP) begin
          state_d = S_HALT;
        end else begin
          state_d = S_HI_REQ;
        end
      end
      S_HI_REQ: begin
        mem_re = 1'b1; addr_w = pc_q; state_d = S_HI_CAP;
      end
      S_HI_CAP: begin
        ir_en = 1'b1; ir_d = {ir_q[23:16], mem_rdata, ir_q[7:0]};
        state_d = S_LO_REQ;
      end
      S_LO_REQ: begin
        mem_re = 1'b1; addr_w = pc_q + 16'd1; state_d = S_LO_CAP;
      end
      S_LO_CAP: begin
        ir_en = 1'b1; ir_d = {ir_q[23:8], mem_rdata};
        pc_en = 1'b1; pc_d = pc_q + 16'd2;
        state_d = S_EXEC;
      end
      S_EXEC: begin
        state_d = S_OP_REQ;
        case (dec_ir.cls)
          C_BR, C_BRN, C_BRZ: begin
            pc_en = alu_take; pc_d = spec;
          end
          C_OUT: begin
            if (dec_ir.direct) state_d = S_DHI_REQ;
            else begin out_valid = 1'b1; out_data = spec[7:0]; end
          end
          C_ADD, C_SUB, C_LD: begin
            if (dec_ir.direct) state_d = S_DHI_REQ;
            else begin acc_en = 1'b1; acc_d = alu_res; end
          end
          C_ST:    state_d = S_WR_HI;
          C_IN:    state_d = S_IN_WAIT;
          default: begin bad_set = 1'b1; state_d = S_HALT; end
        endcase
      end
      S_DHI_REQ: begin
        mem_re = 1'b1; addr_w = spec; state_d = S_DHI_CAP;
      end
      S_DHI_CAP: begin
        if (dec_ir.cls == C_OUT) begin
          out_valid = 1'b1; out_data = mem_rdata; state_d = S_OP_REQ;
        end else begin
          dat_en = 1'b1; dat_d = mem_rdata; state_d = S_DLO_REQ;
        end
      end
      S_DLO_REQ: begin
        mem_re = 1'b1; addr_w = spec + 16'd1; state_d = S_DLO_CAP;
      end
      S_DLO_CAP: begin
        acc_en = 1'b1; acc_d = alu_res; state_d = S_OP_REQ;
      end
      S_WR_HI: begin
        mem_we = 1'b1; addr_w = spec; mem_wdata = acc_q[15:8];
        state_d = S_WR_LO;
      end
      S_WR_LO: begin
        mem_we = 1'b1; addr_w = spec + 16'd1; mem_wdata = acc_q[7:0];
        state_d = S_OP_REQ;
      end
      S_IN_WAIT: begin
        in_ready = 1'b1; addr_w = spec;
        if (in_valid) begin
          mem_we = 1'b1; mem_wdata = in_data; state_d = S_OP_REQ;
        end
      end
      default: begin
        state_d = S_HALT;
      end
    endcase
  end

  assign mem_addr = addr_w[ADDR_W-1:0];
  assign halted   = halt_q;
  assign illegal  = bad_q;

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_OP_REQ;
      pc_q    <= '0;
      acc_q   <= '0;
      ir_q    <= '0;
      dat_q   <= '0;
      halt_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pc_en)  pc_q  <= pc_d;
      if (acc_en) acc_q <= acc_d;
      if (ir_en)  ir_q  <= ir_d;
      if (dat_en) dat_q <= dat_d;
      if (state_d == S_HALT) halt_q <= 1'b1;
      if (bad_set)           bad_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/cpu_acc_chk.sv
module cpu_acc_chk
  import cpu_acc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_re,
  input logic        mem_we,
  input logic [7:0]  mem_wdata,
  input logic        out_valid,
  input logic        in_valid,
  input logic [7:0]  in_data,
  input logic        in_ready,
  input logic        halted,
  input logic        illegal,
  input state_e      state_q,
  input logic [23:0] ir_q
);
  logic fetch_cap;
  assign fetch_cap = (state_q == S_OP_CAP) || (state_q == S_HI_CAP) || (state_q == S_LO_CAP);

  AST_HALT_STICKY:    assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R9
  AST_HALT_QUIET:     assert property (@(posedge clk) disable iff (!rst_n) halted |-> (!mem_re && !mem_we && !out_valid && !in_ready)); // R9
  AST_BAD_HALTS:      assert property (@(posedge clk) disable iff (!rst_n) illegal |-> halted); // R10
  AST_BAD_STICKY:     assert property (@(posedge clk) disable iff (!rst_n) illegal |=> illegal); // R10
  AST_OUT_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R7
  AST_RW_EXCLUSIVE:   assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we)); // R11
  AST_IN_TO_MEM:      assert property (@(posedge clk) disable iff (!rst_n) (in_ready && in_valid) |-> (mem_we && mem_wdata == in_data)); // R8
  AST_IR_FETCH_ONLY:  assert property (@(posedge clk) disable iff (!rst_n) !fetch_cap |=> $stable(ir_q)); // R2
endmodule

bind cpu_acc cpu_acc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_re(mem_re), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .out_valid(out_valid), .in_valid(in_valid),
  .in_data(in_data), .in_ready(in_ready), .halted(halted),
  .illegal(illegal), .state_q(state_q), .ir_q(ir_q)
);

// File: tb/cpu_acc_tb.sv
module cpu_acc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic        mem_re, mem_we;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready, halted, illegal;

  logic [7:0]  mem [MEM_N];
  logic [7:0]  out_log [1024];
  int          out_cnt = 0;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_acc u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .halted(halted), .illegal(illegal)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
    if (rst_n && out_valid) begin
      out_log[out_cnt % 1024] <= out_data;
      out_cnt <= out_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'h00;
  endtask

  task automatic put3(input int a, input logic [7:0] op, input logic [15:0] w);
    mem[a] = op; mem[a+1] = w[15:8]; mem[a+2] = w[7:0];
  endtask

  task automatic hold_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_and_wait(output bit done);
    rst_n = 1'b1;
    done = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (halted) begin done = 1'b1; break; end
    end
  endtask

  function automatic bit is_legal(input logic [7:0] b);
    return b == 8'h00 || b == 8'h04 || b == 8'h08 || b == 8'h0A || b == 8'h49 ||
           b == 8'h50 || b == 8'h51 || b == 8'h70 || b == 8'h71 || b == 8'h80 ||
           b == 8'h81 || b == 8'hC0 || b == 8'hC1 || b == 8'hE1;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    bit done;
    int base;
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;

    // R1 reset state
    clear_mem();
    hold_reset();
    chk("R1 halted in reset", halted, 0);
    chk("R1 illegal in reset", illegal, 0);
    chk("R1 quiet in reset", {out_valid, mem_we, in_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first fetch at 0", {mem_re, mem_addr}, {1'b1, 16'h0000});

    // R4 R3 R2 word assembly and store order
    hold_reset(); clear_mem();
    mem[12'h101] = 8'hA2; mem[12'h102] = 8'h11; mem[12'h103] = 8'h00; mem[12'h104] = 8'hFF;
    put3(0, 8'hC1, 16'h0102); put3(3, 8'hE1, 16'h0200);
    put3(6, 8'hC1, 16'h0101); put3(9, 8'hE1, 16'h0202);
    mem[12] = 8'h00;
    release_and_wait(done);
    chk("R4 load direct n+1", {mem[12'h200], mem[12'h201]}, 16'h1100);
    chk("R4 load direct n", {mem[12'h202], mem[12'h203]}, 16'hA211);
    chk("R9 stop halts legally", {done, illegal}, 2'b10);
    begin
      int busy = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (mem_re || mem_we || !halted) busy++;
      end
      chk("R9 quiet while halted", busy, 0);
    end

    // R5 R3 arithmetic sweep, immediate and direct
    for (int i = 0; i < 20; i++) begin
      logic [15:0] a, b;
      a = 16'(i * 16'h2F31 + (i == 19 ? 16'hFFFF : 16'h0));
      b = 16'(i * 16'h9E37 + 16'h7FFF);
      if (i == 0) begin a = 16'hFFFF; b = 16'h0001; end
      if (i == 1) begin a = 16'h0000; b = 16'h0001; end
      hold_reset(); clear_mem();
      put3(0, 8'hC0, a); put3(3, 8'h70, b); put3(6, 8'hE1, 16'h0200);
      put3(9, 8'hC0, a); put3(12, 8'h81, 16'h0300); put3(15, 8'hE1, 16'h0202);
      mem[18] = 8'h00;
      mem[12'h300] = b[15:8]; mem[12'h301] = b[7:0];
      release_and_wait(done);
      chk("R5 add immediate wrap", {mem[12'h200], mem[12'h201]}, 16'(a + b));
      chk("R5 sub direct wrap", {mem[12'h202], mem[12'h203]}, 16'(a - b));
    end

    // R6 conditional branches over zero, negative and positive accumulators
    for (int i = 0; i < 5; i++) begin
      logic [15:0] v;
      logic [7:0]  exp_ch;
      case (i)
        0: v = 16'h0000; 1: v = 16'h8000; 2: v = 16'hFFFF;
        3: v = 16'h0001; default: v = 16'h7FFF;
      endcase
      exp_ch = (v == 0) ? 8'h5A : (v[15] ? 8'h4E : 8'h50);
      hold_reset(); clear_mem();
      put3(0, 8'hC0, v); put3(3, 8'h0A, 16'h0020); put3(6, 8'h08, 16'h0030);
      put3(9, 8'h50, 16'h0050); mem[12] = 8'h00;
      put3(12'h20, 8'h50, 16'h005A); mem[12'h23] = 8'h00;
      put3(12'h30, 8'h50, 16'h004E); mem[12'h33] = 8'h00;
      base = out_cnt;
      release_and_wait(done);
      chk("R6 one char per branch case", out_cnt - base, 1);
      chk("R6 branch direction", out_log[base % 1024], exp_ch);
    end

    // R6 unconditional branch skips the next instruction
    hold_reset(); clear_mem();
    put3(0, 8'h04, 16'h0040); put3(3, 8'h50, 16'h0058); mem[6] = 8'h00;
    put3(12'h40, 8'h50, 16'h0042); mem[12'h43] = 8'h00;
    base = out_cnt;
    release_and_wait(done);
    chk("R6 jump count", out_cnt - base, 1);
    chk("R6 jump target", out_log[base % 1024], 8'h42);

    // R7 direct character output
    hold_reset(); clear_mem();
    mem[12'h105] = 8'h7E;
    put3(0, 8'h51, 16'h0105); mem[3] = 8'h00;
    base = out_cnt;
    release_and_wait(done);
    chk("R7 direct char count", out_cnt - base, 1);
    chk("R7 direct char value", out_log[base % 1024], 8'h7E);

    // R8 input stall, then write and echo
    hold_reset(); clear_mem();
    mem[12'h210] = 8'hEE;
    put3(0, 8'h49, 16'h0210); put3(3, 8'h51, 16'h0210); mem[6] = 8'h00;
    base = out_cnt;
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R8 waits with ready", {in_ready, halted}, 2'b10);
    chk("R8 no write while waiting", mem[12'h210], 8'hEE);
    chk("R8 no output while waiting", out_cnt - base, 0);
    in_data = 8'h5A; in_valid = 1'b1;
    release_and_wait(done);
    in_valid = 1'b0;
    chk("R8 byte stored", mem[12'h210], 8'h5A);
    chk("R8 byte echoed", out_log[base % 1024], 8'h5A);

    // R10 R2 exhaustive opcode sweep
    begin
      int wrong = 0;
      in_valid = 1'b1; in_data = 8'h00;
      for (int op = 0; op < 256; op++) begin
        hold_reset(); clear_mem();
        put3(0, 8'(op), 16'h0200); mem[3] = 8'h00;
        mem[12'h200] = 8'h00; mem[12'h201] = 8'h00;
        release_and_wait(done);
        if (!done || illegal != !is_legal(8'(op))) begin
          wrong++;
          if (wrong < 5)
            $display("FAIL R10 opcode %0h actual=%0b expected=%0b", op, illegal, !is_legal(8'(op)));
        end
      end
      in_valid = 1'b0;
      chk("R10 opcode legality sweep", wrong, 0);
    end

    // R10 store immediate is rejected without a write
    hold_reset(); clear_mem();
    mem[12'h300] = 8'h33;
    put3(0, 8'hC0, 16'h1234); put3(3, 8'hE0, 16'h0300); mem[6] = 8'h00;
    release_and_wait(done);
    chk("R10 E0 flags illegal", {halted, illegal}, 2'b11);
    chk("R10 E0 writes nothing", mem[12'h300], 8'h33);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule